// File: doc/BRIEF.md
# Byte Stack with Pointer Register

This block keeps a small last-in, first-out store of bytes for a simple processor core. A 64-entry byte array is addressed by an 8-bit stack pointer. Only the low six bits of the pointer select an entry, so the pointer may roam over its full 8-bit range while the storage repeats every 64 values. The pointer comes out of reset at 0x40, so the first entry pushed lands at index 63.

A sequencer outside this block drives four single-cycle strobes and one data byte. It uses them to build pushes, pops, subroutine calls and returns, and a two-byte save of the accumulator and flags. A push is a pointer decrement in one step and a write at the new pointer in the next step. A pop is a read at the pointer in one step and an increment in the next step.

In any cycle, a write and a read both use the pointer value held before that cycle's update. The top-of-stack output and the pointer output both come straight from registers.

Top module: `stack_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `sp_o` becomes 0x40 and `tos_o` becomes 0x00. Storage contents are not changed by reset.
- R2: When `dec_i` is 1 and `inc_i` is 0 at an edge, `sp_o` becomes the old value minus one, modulo 256 (0x00 becomes 0xFF).
- R3: When `inc_i` is 1 and `dec_i` is 0 at an edge, `sp_o` becomes the old value plus one, modulo 256 (0xFF becomes 0x00).
- R4: When `inc_i` and `dec_i` are both 1 at an edge, the request is treated as a conflict and `sp_o` keeps its value.
- R5: `wr_i` stores `din_i` at index `sp_o[5:0]`, taking the pointer before that edge's update. Pointer values that differ by a multiple of 64 address the same byte.
- R6: `rd_i` loads `tos_o` with the byte at index `sp_o[5:0]`, taking the pointer before that edge's update. While `rd_i` is 0, `tos_o` holds its value.
- R7: A read and a write at the same edge return the byte stored before that write (read-first).
- R8: A push is a decrement step followed by a write step. Starting from reset, the first push stores its byte at index 63 and leaves `sp_o` at 0x3F.
- R9: A pop is a read step followed by an increment step. It returns the most recently pushed byte and restores the pointer to its value before that push.
- R10: The accumulator-and-flags save is two pushes, the accumulator first and the flags second. Two pops then return the flags first and the accumulator second, and the pointer ends where it started.
- R11: A call pushes the return address. Nested calls followed by returns give back the saved addresses in reverse order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| dec_i | input | 1 | Decrement-pointer strobe |
| inc_i | input | 1 | Increment-pointer strobe |
| wr_i | input | 1 | Write `din_i` at the current pointer |
| rd_i | input | 1 | Read the byte at the current pointer into `tos_o` |
| din_i | input | 8 | Byte to store |
| tos_o | output | 8 | Registered byte from the last read |
| sp_o | output | 8 | Registered stack pointer |

## Verification
The assertions check the pointer arithmetic on every cycle: decrement, increment, the conflict hold, and the wrap at both ends of the 8-bit range. They also check that `tos_o` holds while no read is requested and that reset loads 0x40. Which byte a read returns depends on the contents of the storage. The bench scenarios therefore show those cases: the read-first behaviour, aliasing through the low six pointer bits, and the last-in, first-out ordering of pushes, calls and the accumulator-and-flags pair.

// File: rtl/stack_pkg.sv
package stack_pkg;

  typedef enum logic [1:0] {
    PTR_HOLD     = 2'd0,
    PTR_DOWN     = 2'd1,
    PTR_UP       = 2'd2,
    PTR_CONFLICT = 2'd3
  } ptr_act_e;

  function automatic ptr_act_e decode_ptr_act(input logic down, input logic up);
    ptr_act_e a;
    unique case ({up, down})
      2'b01:   a = PTR_DOWN;
      2'b10:   a = PTR_UP;
      2'b11:   a = PTR_CONFLICT;
      default: a = PTR_HOLD;
    endcase
    return a;
  endfunction

endpackage

// File: rtl/stack_ptr_reg.sv
module stack_ptr_reg #(
  parameter int          PTR_W     = 8,
  parameter logic [7:0]  RESET_VAL = 8'h40
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             down_i,
  input  logic             up_i,
  output logic [PTR_W-1:0] ptr_o
);
  import stack_pkg::*;

  localparam logic [PTR_W-1:0] ONE  = PTR_W'(1);
  localparam logic [PTR_W-1:0] INIT = PTR_W'(RESET_VAL);

  ptr_act_e         act;
  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] ptr_d;

  always_comb begin
    act = decode_ptr_act(down_i, up_i);
    unique case (act)
      PTR_DOWN: ptr_d = ptr_q - ONE;
      PTR_UP:   ptr_d = ptr_q + ONE;
      default:  ptr_d = ptr_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) ptr_q <= INIT;
    else     ptr_q <= ptr_d;
  end

  assign ptr_o = ptr_q;

endmodule

// File: rtl/stack_store_ram.sv
module stack_store_ram #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64,
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] cells [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (we_i) cells[idx_i] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (rst)       rdata_q <= '0;
    else if (re_i) rdata_q <= cells[idx_i];
  end

  assign rdata_o = rdata_q;

endmodule

// File: rtl/stack_unit.sv
module stack_unit #(
  parameter int         DATA_W   = 8,
  parameter int         PTR_W    = 8,
  parameter int         DEPTH    = 64,
  parameter logic [7:0] SP_RESET = 8'h40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dec_i,
  input  logic              inc_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] din_i,
  output logic [DATA_W-1:0] tos_o,
  output logic [PTR_W-1:0]  sp_o
);
  localparam int IDX_W = $clog2(DEPTH);

  logic [PTR_W-1:0] sp_q;
  logic [IDX_W-1:0] idx;

  stack_ptr_reg #(.PTR_W(PTR_W), .RESET_VAL(SP_RESET)) u_ptr (
    .clk    (clk),
    .rst    (rst),
    .down_i (dec_i),
    .up_i   (inc_i),
    .ptr_o  (sp_q)
  );

  generate
    if (PTR_W > IDX_W) begin : g_fold
      assign idx = sp_q[IDX_W-1:0];
    end else begin : g_pad
      assign idx = IDX_W'(sp_q);
    end
  endgenerate

  stack_store_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_ram (
    .clk     (clk),
    .rst     (rst),
    .we_i    (wr_i),
    .re_i    (rd_i),
    .idx_i   (idx),
    .wdata_i (din_i),
    .rdata_o (tos_o)
  );

  assign sp_o = sp_q;

endmodule

// File: rtl/stack_unit_chk.sv
module stack_unit_chk #(
  parameter int         DATA_W   = 8,
  parameter int         PTR_W    = 8,
  parameter logic [7:0] SP_RESET = 8'h40
) (
  input logic              clk,
  input logic              rst,
  input logic              dec_i,
  input logic              inc_i,
  input logic              rd_i,
  input logic [DATA_W-1:0] tos_o,
  input logic [PTR_W-1:0]  sp_o
);
  logic rst_seen = 1'b0;

  always_ff @(posedge clk) rst_seen <= rst;

  // R1: one edge after reset was sampled, the pointer holds its reset value
  always @(negedge clk) begin
    if (rst_seen) begin
      assert_reset_ptr_R1: assert (sp_o == PTR_W'(SP_RESET));
    end
  end

  assert_dec_step_R2: assert property (@(posedge clk) disable iff (rst)
    (dec_i && !inc_i) |=> (sp_o == $past(sp_o) - PTR_W'(1)));

  assert_inc_step_R3: assert property (@(posedge clk) disable iff (rst)
    (inc_i && !dec_i) |=> (sp_o == $past(sp_o) + PTR_W'(1)));

  assert_conflict_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (inc_i && dec_i) |=> $stable(sp_o));

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!inc_i && !dec_i) |=> $stable(sp_o));

  assert_tos_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !rd_i |=> $stable(tos_o));

endmodule

bind stack_unit stack_unit_chk #(.DATA_W(DATA_W), .PTR_W(PTR_W), .SP_RESET(SP_RESET)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .dec_i (dec_i),
  .inc_i (inc_i),
  .rd_i  (rd_i),
  .tos_o (tos_o),
  .sp_o  (sp_o)
);

// File: tb/stack_unit_bench.sv
`timescale 1ns/100ps
module stack_unit_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       dec_i = 1'b0, inc_i = 1'b0, wr_i = 1'b0, rd_i = 1'b0;
  logic [7:0] din_i = 8'h00;
  logic [7:0] tos_o, sp_o;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  logic [7:0] m_mem [64];
  logic [7:0] m_sp  = 8'h40;
  logic [7:0] m_tos = 8'h00;

  always #2.5 clk = ~clk;

  stack_unit u_stack_unit (
    .clk(clk), .rst(rst), .dec_i(dec_i), .inc_i(inc_i), .wr_i(wr_i),
    .rd_i(rd_i), .din_i(din_i), .tos_o(tos_o), .sp_o(sp_o)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] next_sp(input logic [7:0] sp, input bit d, input bit i);
    if (d && !i) return sp - 8'd1;
    if (i && !d) return sp + 8'd1;
    return sp;
  endfunction

  // one clocked step; inputs applied after a falling edge, outputs checked at the next one
  task automatic step(input bit d, input bit i, input bit w, input bit r, input logic [7:0] din,
                      input string tag);
    logic [5:0] ix;
    ix = m_sp[5:0];
    dec_i = d; inc_i = i; wr_i = w; rd_i = r; din_i = din;
    @(posedge clk);
    if (r) m_tos = m_mem[ix];
    if (w) m_mem[ix] = din;
    m_sp = next_sp(m_sp, d, i);
    @(negedge clk);
    dec_i = 0; inc_i = 0; wr_i = 0; rd_i = 0;
    chk({tag, " sp"}, sp_o, m_sp);
    chk({tag, " tos"}, tos_o, m_tos);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    m_sp = 8'h40; m_tos = 8'h00;
    chk("R1 reset sp", sp_o, 8'h40);
    chk("R1 reset tos", tos_o, 8'h00);
    rst = 1'b0;
  endtask

  task automatic push(input logic [7:0] b, input string tag);
    step(1, 0, 0, 0, 8'h00, tag);
    step(0, 0, 1, 0, b, tag);
  endtask

  task automatic pop(input string tag);
    step(0, 0, 0, 1, 8'h00, tag);
    step(0, 1, 0, 0, 8'h00, tag);
  endtask

  initial begin
    logic [7:0] tos_after;
    void'($urandom(32'd1234));
    @(negedge clk);
    do_reset();

    // fill all 64 entries: write at current pointer then step down (R5 index fold)
    for (int k = 0; k < 64; k++) step(1, 0, 1, 0, 8'(k * 3 + 1), "R5 fill");
    chk("R2 after fill", sp_o, 8'h00);
    step(1, 0, 0, 0, 8'h00, "R2 wrap down");
    chk("R2 0x00 -> 0xFF", sp_o, 8'hFF);
    step(0, 1, 0, 0, 8'h00, "R3 wrap up");
    chk("R3 0xFF -> 0x00", sp_o, 8'h00);

    do_reset();
    // R8: first push from reset lands at index 63
    push(8'hA5, "R8 push");
    chk("R8 sp after push", sp_o, 8'h3F);
    step(0, 0, 0, 1, 8'h00, "R8 read");
    chk("R8 byte at index 63", tos_o, 8'hA5);
    step(0, 1, 0, 0, 8'h00, "R9 inc");
    chk("R9 pointer restored", sp_o, 8'h40);

    // R6: no read keeps tos
    tos_after = tos_o;
    step(1, 0, 1, 0, 8'h5A, "R6 idle");
    chk("R6 tos held", tos_o, tos_after);
    step(0, 1, 0, 0, 8'h00, "R6 back");

    // R4: conflict
    step(1, 1, 0, 0, 8'h00, "R4 conflict");
    chk("R4 sp unchanged", sp_o, 8'h40);

    // R10: accumulator then flags
    push(8'h3C, "R10 acc");
    push(8'h81, "R10 flags");
    chk("R10 sp two down", sp_o, 8'h3E);
    pop("R10 pop1");
    chk("R10 flags first", tos_o, 8'h81);
    pop("R10 pop2");
    chk("R10 acc second", tos_o, 8'h3C);
    chk("R10 sp restored", sp_o, 8'h40);

    // R11: nested call / return
    push(8'h57, "R11 call1");
    push(8'h90, "R11 call2");
    pop("R11 ret1");
    chk("R11 inner return", tos_o, 8'h90);
    pop("R11 ret2");
    chk("R11 outer return", tos_o, 8'h57);

    // R7: read-first on same-edge read and write
    step(0, 0, 1, 0, 8'h22, "R7 seed");
    step(0, 0, 1, 1, 8'h33, "R7 both");
    chk("R7 old byte returned", tos_o, 8'h22);
    step(0, 0, 0, 1, 8'h00, "R7 reread");
    chk("R7 new byte stored", tos_o, 8'h33);

    // R5: pointer 0x40 and 0x80 alias to index 0
    step(0, 0, 1, 0, 8'h11, "R5 write at 0x40");
    for (int k = 0; k < 64; k++) step(0, 1, 0, 0, 8'h00, "R5 climb");
    chk("R5 sp 0x80", sp_o, 8'h80);
    step(0, 0, 0, 1, 8'h00, "R5 alias read");
    chk("R5 alias byte", tos_o, 8'h11);

    // random mix against the bench model (R2 R3 R4 R5 R6 R7)
    for (int k = 0; k < 4000; k++) begin
      bit d, i, w, r;
      d = ($urandom_range(0, 99) < 35);
      i = ($urandom_range(0, 99) < 35);
      w = ($urandom_range(0, 99) < 40);
      r = ($urandom_range(0, 99) < 40);
      step(d, i, w, r, 8'($urandom), "random R2 R3 R4 R5 R6");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(150000 * 5);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule